// File: doc/BRIEF.md
# Dual-Segment Address Relocator

This block turns effective addresses into physical addresses using a base-plus-limit scheme with two independent segments. One segment serves instruction fetches and the other serves loads and stores. Each segment has its own base register and its own limit register. An access is legal only when its effective address is below the segment's limit. A legal access gets the base added to its address. An access that breaks the limit is flagged as a fault, and no physical address is produced for it.

Both translations are purely combinational and use separate hardware, so a fetch and a data access resolve in the same cycle as their requests. The four registers can be loaded only through a configuration port. That port accepts a write only when a privilege qualifier is high, and a two-bit selector picks which register the write goes to. In a pipeline, the instruction stage drives the fetch port and the memory stage drives the data port.

Top module: `segXlate`

## Requirements
- R1: After reset, all four registers read as zero. Every request therefore faults, because any address is greater than or equal to a zero limit.
- R2: A fetch request with address A and program limit L, where A < L, gives fetchValid=1, fetchFault=0 and fetchPhys = program base + A, in the same cycle as the request.
- R3: A data request is judged only against the data base and data limit, using the same rule as R2, and drives dataValid, dataFault and dataPhys.
- R4: A request whose address is greater than or equal to the selected limit, compared as unsigned numbers, asserts the fault output of its port in the same cycle. The valid output of that port stays low and its physical address reads zero.
- R5: An address exactly one below the limit is legal, and an address equal to the limit faults.
- R6: A write with cfgWrEn=1 and cfgPriv=1 loads cfgData into the register picked by cfgSel: 0 is the program base, 1 the program limit, 2 the data base and 3 the data limit. The new value governs translations from the cycle after the clock edge that takes the write.
- R7: A write with cfgPriv=0 changes no register.
- R8: Fetch and data requests in the same cycle are translated independently. Each uses only its own segment, and a fault on one port does not affect the other port.
- R9: A port with no request drives valid=0, fault=0 and a physical address of zero.
- R10: The sum of base and address wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write request |
| cfgPriv | input | 1 | Privilege qualifier; a write is accepted only when this is high |
| cfgSel | input | 2 | Register selector (0 program base, 1 program limit, 2 data base, 3 data limit) |
| cfgData | input | AW | Value to write |
| fetchReq | input | 1 | Instruction fetch request |
| fetchAddr | input | AW | Fetch effective address |
| fetchPhys | output | AW | Fetch physical address (zero unless valid) |
| fetchValid | output | 1 | Fetch translated legally |
| fetchFault | output | 1 | Fetch broke the program limit |
| dataReq | input | 1 | Load/store request |
| dataAddr | input | AW | Data effective address |
| dataPhys | output | AW | Data physical address (zero unless valid) |
| dataValid | output | 1 | Data access translated legally |
| dataFault | output | 1 | Data access broke the data limit |

## Verification
A fetch and a data access can land in the same cycle. The bench does this by raising both requests together with equal effective addresses, so any mix-up of segment registers between the ports would show up as a wrong physical address. It also drives mixed cycles in which one port faults while the other translates legally. For each port, the scoreboard compares valid, fault and physical address against values computed from a reference copy of the register contents that the bench keeps itself.

// File: rtl/segXlatePkg.sv
`timescale 1ns/100ps
package segXlatePkg;
  localparam int NLANE      = 2;
  localparam int LANE_FETCH = 0;
  localparam int LANE_DATA  = 1;

  typedef enum logic [1:0] {
    SEL_PROG_BASE  = 2'd0,
    SEL_PROG_LIMIT = 2'd1,
    SEL_DATA_BASE  = 2'd2,
    SEL_DATA_LIMIT = 2'd3
  } cfgSelT;

  typedef struct packed {
    logic progBase;
    logic progLimit;
    logic dataBase;
    logic dataLimit;
  } cfgStrobeT;
endpackage

// File: rtl/segCtrl.sv
`timescale 1ns/100ps
module segCtrl
  import segXlatePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWrEn,
  input  logic      cfgPriv,
  input  logic [1:0] cfgSel,
  output cfgStrobeT strobe
);
  always_comb begin
    strobe = '0;
    if (cfgWrEn && cfgPriv) begin
      case (cfgSelT'(cfgSel))
        SEL_PROG_BASE:  strobe.progBase  = 1'b1;
        SEL_PROG_LIMIT: strobe.progLimit = 1'b1;
        SEL_DATA_BASE:  strobe.dataBase  = 1'b1;
        SEL_DATA_LIMIT: strobe.dataLimit = 1'b1;
        default:        strobe = '0;
      endcase
    end
  end

  // R7
  unpriv_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgPriv |-> ($countones(strobe) == 0));

  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
endmodule

// File: rtl/segLane.sv
`timescale 1ns/100ps
module segLane #(
  parameter int AW = 32
) (
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] phys,
  output logic          valid,
  output logic          fault
);
  logic inRange;
  logic [AW-1:0] sum;

  always_comb begin
    inRange = addr < limit;
    sum     = base + addr;
    valid   = req & inRange;
    fault   = req & ~inRange;
    phys    = valid ? sum : '0;
  end
endmodule

// File: rtl/segDatapath.sv
`timescale 1ns/100ps
module segDatapath
  import segXlatePkg::*;
#(
  parameter int AW = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cfgStrobeT                  strobe,
  input  logic [AW-1:0]              cfgData,
  input  logic [NLANE-1:0]           reqIn,
  input  logic [NLANE-1:0][AW-1:0]   addrIn,
  output logic [NLANE-1:0][AW-1:0]   physOut,
  output logic [NLANE-1:0]           validOut,
  output logic [NLANE-1:0]           faultOut
);
  logic [NLANE-1:0][AW-1:0] baseQ;
  logic [NLANE-1:0][AW-1:0] limitQ;
  logic [NLANE-1:0]         wrBase;
  logic [NLANE-1:0]         wrLimit;

  always_comb begin
    wrBase  = '0;
    wrLimit = '0;
    wrBase[LANE_FETCH]  = strobe.progBase;
    wrLimit[LANE_FETCH] = strobe.progLimit;
    wrBase[LANE_DATA]   = strobe.dataBase;
    wrLimit[LANE_DATA]  = strobe.dataLimit;
  end

  for (genvar g = 0; g < NLANE; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[g]  <= '0;
        limitQ[g] <= '0;
      end else begin
        if (wrBase[g])  baseQ[g]  <= cfgData;
        if (wrLimit[g]) limitQ[g] <= cfgData;
      end
    end

    segLane #(.AW(AW)) u_lane (
      .req  (reqIn[g]),
      .addr (addrIn[g]),
      .base (baseQ[g]),
      .limit(limitQ[g]),
      .phys (physOut[g]),
      .valid(validOut[g]),
      .fault(faultOut[g])
    );

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      !reqIn[g] |-> (!validOut[g] && !faultOut[g] && physOut[g] == '0));

    // R4
    fault_blocks_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
      faultOut[g] |-> (!validOut[g] && physOut[g] == '0));

    // R5
    valid_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      validOut[g] |-> (addrIn[g] < limitQ[g]));

    // R7
    base_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !wrBase[g] |=> $stable(baseQ[g]));

    // R7
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !wrLimit[g] |=> $stable(limitQ[g]));
  end
endmodule

// File: rtl/segXlate.sv
`timescale 1ns/100ps
module segXlate
  import segXlatePkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWrEn,
  input  logic          cfgPriv,
  input  logic [1:0]    cfgSel,
  input  logic [AW-1:0] cfgData,
  input  logic          fetchReq,
  input  logic [AW-1:0] fetchAddr,
  output logic [AW-1:0] fetchPhys,
  output logic          fetchValid,
  output logic          fetchFault,
  input  logic          dataReq,
  input  logic [AW-1:0] dataAddr,
  output logic [AW-1:0] dataPhys,
  output logic          dataValid,
  output logic          dataFault
);
  cfgStrobeT strobe;
  logic [NLANE-1:0]         reqV;
  logic [NLANE-1:0][AW-1:0] addrV;
  logic [NLANE-1:0][AW-1:0] physV;
  logic [NLANE-1:0]         validV;
  logic [NLANE-1:0]         faultV;

  segCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgWrEn(cfgWrEn),
    .cfgPriv(cfgPriv),
    .cfgSel (cfgSel),
    .strobe (strobe)
  );

  always_comb begin
    reqV  = '0;
    addrV = '0;
    reqV[LANE_FETCH]  = fetchReq;
    addrV[LANE_FETCH] = fetchAddr;
    reqV[LANE_DATA]   = dataReq;
    addrV[LANE_DATA]  = dataAddr;
  end

  segDatapath #(.AW(AW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgData (cfgData),
    .reqIn   (reqV),
    .addrIn  (addrV),
    .physOut (physV),
    .validOut(validV),
    .faultOut(faultV)
  );

  assign fetchPhys  = physV[LANE_FETCH];
  assign fetchValid = validV[LANE_FETCH];
  assign fetchFault = faultV[LANE_FETCH];
  assign dataPhys   = physV[LANE_DATA];
  assign dataValid  = validV[LANE_DATA];
  assign dataFault  = faultV[LANE_DATA];

  // R8
  fetch_isolated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && $stable(fetchAddr) && $past(fetchReq) && !$past(cfgWrEn))
      |-> $stable(fetchPhys));
endmodule

// File: tb/segXlate_tb.sv
`timescale 1ns/100ps
module segXlate_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0, cfgPriv = 1'b0;
  logic [1:0]    cfgSel = '0;
  logic [AW-1:0] cfgData = '0;
  logic          fetchReq = 1'b0, dataReq = 1'b0;
  logic [AW-1:0] fetchAddr = '0, dataAddr = '0;
  logic [AW-1:0] fetchPhys, dataPhys;
  logic          fetchValid, fetchFault, dataValid, dataFault;

  always #2 clk = ~clk;

  segXlate #(.AW(AW)) u_dut (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgPriv(cfgPriv), .cfgSel(cfgSel), .cfgData(cfgData),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchPhys(fetchPhys), .fetchValid(fetchValid), .fetchFault(fetchFault),
    .dataReq(dataReq), .dataAddr(dataAddr),
    .dataPhys(dataPhys), .dataValid(dataValid), .dataFault(dataFault)
  );

  typedef struct {
    logic          fV; logic fF; logic [AW-1:0] fP;
    logic          dV; logic dF; logic [AW-1:0] dP;
    string         tag;
  } expT;

  expT expQ[$];
  int checks = 0;
  int errors = 0;
  logic [AW-1:0] mBase[2];
  logic [AW-1:0] mLimit[2];
  bit finished = 0;

  function automatic void model(input logic req, input logic [AW-1:0] a,
                                input logic [AW-1:0] b, input logic [AW-1:0] l,
                                output logic v, output logic f, output logic [AW-1:0] p);
    v = req && (a < l);
    f = req && !(a < l);
    p = v ? (b + a) : '0;
  endfunction

  task automatic access(input logic fr, input logic [AW-1:0] fa,
                        input logic dr, input logic [AW-1:0] da, input string tag);
    expT e;
    @(negedge clk); #0.5;
    fetchReq = fr; fetchAddr = fa; dataReq = dr; dataAddr = da;
    model(fr, fa, mBase[0], mLimit[0], e.fV, e.fF, e.fP);
    model(dr, da, mBase[1], mLimit[1], e.dV, e.dF, e.dP);
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [AW-1:0] d, input logic priv);
    @(negedge clk); #0.5;
    fetchReq = 0; dataReq = 0;
    cfgWrEn = 1; cfgPriv = priv; cfgSel = sel; cfgData = d;
    if (priv) begin
      case (sel)
        2'd0: mBase[0] = d;
        2'd1: mLimit[0] = d;
        2'd2: mBase[1] = d;
        default: mLimit[1] = d;
      endcase
    end
    @(negedge clk); #0.5;
    cfgWrEn = 0; cfgPriv = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (expQ.size() > 0) begin
        expT e;
        e = expQ.pop_front();
        checks++;
        if (fetchValid !== e.fV || fetchFault !== e.fF || fetchPhys !== e.fP ||
            dataValid !== e.dV || dataFault !== e.dF || dataPhys !== e.dP) begin
          errors++;
          $display("FAIL %s: fetch v/f/p=%0b/%0b/%h exp %0b/%0b/%h data v/f/p=%0b/%0b/%h exp %0b/%0b/%h",
                   e.tag, fetchValid, fetchFault, fetchPhys, e.fV, e.fF, e.fP,
                   dataValid, dataFault, dataPhys, e.dV, e.dF, e.dP);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin mBase[i] = '0; mLimit[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    access(1, 32'h0, 1, 32'h5, "R1 reset zero limits fault");
    access(0, 32'h123, 0, 32'h456, "R9 no request quiet");
    cfgWrite(2'd0, 32'h0000_1000, 1);
    cfgWrite(2'd1, 32'h0000_0100, 1);
    cfgWrite(2'd2, 32'h0000_8000, 1);
    cfgWrite(2'd3, 32'h0000_0040, 1);
    access(1, 32'h10, 0, 32'h0, "R2 fetch program pair");
    access(0, 32'h0, 1, 32'h3f, "R3 R5 data pair last legal");
    access(1, 32'hff, 0, 32'h0, "R5 fetch limit minus one");
    access(1, 32'h100, 0, 32'h0, "R4 R5 fetch at limit faults");
    access(0, 32'h0, 1, 32'h40, "R4 data at limit faults");
    access(1, 32'h20, 1, 32'h20, "R8 both ports same address");
    access(1, 32'h200, 1, 32'h8, "R8 fetch fault data ok");
    access(1, 32'h8, 1, 32'h41, "R8 fetch ok data fault");
    cfgWrite(2'd2, 32'h0000_dead, 0);
    access(0, 32'h0, 1, 32'h10, "R7 unprivileged base write ignored");
    cfgWrite(2'd1, 32'h0000_0000, 0);
    access(1, 32'h50, 0, 32'h0, "R7 unprivileged limit write ignored");
    cfgWrite(2'd1, 32'h0000_0200, 1);
    access(1, 32'h150, 0, 32'h0, "R6 program limit rewrite");
    access(1, 32'h8000_0000, 0, 32'h0, "R4 unsigned compare");
    cfgWrite(2'd2, 32'hffff_fff0, 1);
    cfgWrite(2'd3, 32'hffff_ffff, 1);
    access(1, 32'h30, 1, 32'h20, "R10 wrap modulo and R6 data regs");
    access(0, 32'h0, 0, 32'h0, "R9 idle after traffic");
    repeat (4) @(negedge clk);
    wait (expQ.size() == 0);
    @(negedge clk); #2;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule